// File: doc/BRIEF.md
# PCI function configuration state controller

This block holds the configuration state of a small set of PCI functions and answers configure, deconfigure and reset requests for them. Each function sits in one of five states: reserved, standby, disabled, enabled or blocked. A request names a function by its 32-bit identifier and carries a request length. The block finds the function in its table, checks the request, moves the function to its new state and returns a 16-bit response code. Deconfiguring a function that still owns interrupt routing or an address translation table raises a one-cycle teardown strobe for each such resource. The teardown itself happens outside the block.

The table contents are strap inputs. The block copies them into the table on every clock cycle while reset is held. From the strapped state it derives each function handle: the low index bits hold the table slot, and bit 31 is the enable bit.

Beside the state machine sits an eight-entry queue of service events. Producers push error events (class 1) and availability events (class 2). A consumer reads the oldest event at the head outputs, removes it with a pop pulse, and watches a pending flag to see whether anything is waiting.

Top module: `fn_cfg_ctrl`

## Requirements
- R1: While reset is held, each table slot takes its identifier, state (reserved 0, standby 1, disabled 2, enabled 3, blocked 4) and resource flags from the straps. The handle of slot i is i in its low index bits, with bit 31 set only when the strapped state is enabled or blocked. After reset the event queue is empty, the overflow flag is clear and no response is pending.
- R2: A request whose length is below 16 answers 0x0300 and changes nothing. The length is checked before the identifier is looked up, so an unknown identifier with a short length also answers 0x0300. A length of exactly 16 is accepted.
- R3: A request whose identifier matches no slot answers 0x09F0.
- R4: Any request to a reserved function answers 0x0009, and the function stays reserved.
- R5: Configure (op 0) moves a standby function to disabled and answers 0x0010. In the disabled, enabled or blocked state it answers 0x0020 and changes nothing.
- R6: Deconfigure (op 1) of a standby function answers 0x0020 and raises no strobe. Deconfigure in the disabled, enabled or blocked state moves the function to standby and answers 0x0010. In the same cycle it pulses the interrupt-teardown strobe only if the function's interrupt resource is active, and the translation-teardown strobe only if its translation resource is active. The down-index output gives the slot. Each pulsed resource is then marked inactive, so a later deconfigure does not pulse it again.
- R7: Reset (op 2) of a standby function answers 0x0020 and changes nothing. In the disabled, enabled or blocked state it moves the function to disabled, clears bit 31 of its handle and answers 0x0010.
- R8: A request sampled at a rising edge gives a one-cycle response valid pulse after the following rising edge. The pulse carries the code and any teardown strobes, and the table update becomes visible in the same cycle. Op code 3 gives no response.
- R9: When several slots share an identifier, the lowest-numbered slot serves the request and the others are untouched.
- R10: Events leave the queue in the order they arrived. A class 1 event keeps its identifier, handle, error word, 64-bit faulting address and event code. A class 2 event keeps its identifier, handle and code, and reads back zero for the error word and the address. Pushes with class 0 or 3 are discarded.
- R11: The pending flag equals "queue not empty". A pop removes the head entry. A pop on an empty queue has no effect.
- R12: A push into a full queue (8 entries) is dropped and sets an overflow flag that stays set until reset. A push together with a pop on a full queue performs both and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are loaded while low |
| strap_fid_i | input | 8x32 | Identifier of each slot |
| strap_state_i | input | 8x3 | Initial state of each slot |
| strap_irq_i | input | 8 | Interrupt resource active at reset, per slot |
| strap_xlat_i | input | 8 | Translation resource active at reset, per slot |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 configure, 1 deconfigure, 2 reset, 3 none |
| req_fid_i | input | 32 | Target function identifier |
| req_len_i | input | 16 | Request length |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_code_o | output | 16 | Response code |
| irq_down_o | output | 1 | Interrupt teardown strobe |
| xlat_down_o | output | 1 | Translation teardown strobe |
| down_idx_o | output | 3 | Slot being torn down |
| fn_state_o | output | 8x3 | Current state of each slot |
| fn_handle_o | output | 8x32 | Current handle of each slot |
| evt_push_i | input | 1 | Event push strobe |
| evt_cls_i | input | 2 | Event class: 1 error, 2 availability |
| evt_fid_i | input | 32 | Event function identifier |
| evt_fh_i | input | 32 | Event function handle |
| evt_err_i | input | 32 | Event error word |
| evt_addr_i | input | 64 | Event faulting address |
| evt_code_i | input | 16 | Event code |
| evt_pop_i | input | 1 | Remove the head event |
| evt_pending_o | output | 1 | Queue not empty |
| evt_cls_o | output | 2 | Head event class |
| evt_fid_o | output | 32 | Head event identifier |
| evt_fh_o | output | 32 | Head event handle |
| evt_err_o | output | 32 | Head event error word |
| evt_addr_o | output | 64 | Head event address |
| evt_code_o | output | 16 | Head event code |
| evt_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bound checker watches every cycle for the following:
- a response arrives two edges after each real request, and never without one;
- every response code is one of the five legal values;
- a teardown strobe appears only with a normal-completion response;
- a reserved slot never leaves the reserved state;
- an accepted push leaves the pending flag set;
- an idle empty queue stays empty;
- the overflow flag never clears.

Only the directed scenarios can show the rest:
- the state-dependent choice between codes;
- the lowest-slot rule for duplicate identifiers;
- the clearing of the handle's enable bit;
- the one-shot nature of the teardown strobes;
- the zeroed fields of availability events;
- the exact arrival order and dropping behaviour of the queue.

// File: rtl/fn_cfg_pkg.sv
package fn_cfg_pkg;

    localparam int FID_W     = 32;
    localparam int FH_W      = 32;
    localparam int LEN_W     = 16;
    localparam int RC_W      = 16;
    localparam int MIN_LEN   = 16;
    localparam int FH_EN_BIT = 31;

    typedef enum logic [2:0] {
        FS_RSV  = 3'd0,
        FS_STBY = 3'd1,
        FS_DIS  = 3'd2,
        FS_ENA  = 3'd3,
        FS_BLK  = 3'd4
    } fn_state_e;

    typedef enum logic [1:0] {
        OP_CFG   = 2'd0,
        OP_DECFG = 2'd1,
        OP_RST   = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

    localparam logic [RC_W-1:0] RC_NORMAL  = 16'h0010;
    localparam logic [RC_W-1:0] RC_NOACT   = 16'h0020;
    localparam logic [RC_W-1:0] RC_RSV     = 16'h0009;
    localparam logic [RC_W-1:0] RC_SHORT   = 16'h0300;
    localparam logic [RC_W-1:0] RC_UNKNOWN = 16'h09F0;

    localparam logic [1:0] CLS_ERR   = 2'd1;
    localparam logic [1:0] CLS_AVAIL = 2'd2;

    typedef struct packed {
        logic [1:0]       cls;
        logic [FID_W-1:0] fid;
        logic [FH_W-1:0]  fh;
        logic [31:0]      err;
        logic [63:0]      addr;
        logic [15:0]      code;
    } evt_t;

endpackage

// File: rtl/fn_table.sv
module fn_table
    import fn_cfg_pkg::*;
#(
    parameter int N_FN  = 8,
    parameter int IDX_W = $clog2(N_FN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_FN-1:0][FID_W-1:0]   strap_fid_i,
    input  logic [N_FN-1:0][2:0]         strap_state_i,
    input  logic [N_FN-1:0]              strap_irq_i,
    input  logic [N_FN-1:0]              strap_xlat_i,
    input  logic                         upd_en_i,
    input  logic [IDX_W-1:0]             upd_idx_i,
    input  logic [2:0]                   upd_state_i,
    input  logic                         upd_clr_en_i,
    input  logic                         upd_clr_irq_i,
    input  logic                         upd_clr_xlat_i,
    output logic [N_FN-1:0][FID_W-1:0]   tbl_fid_o,
    output logic [N_FN-1:0][2:0]         tbl_state_o,
    output logic [N_FN-1:0][FH_W-1:0]    tbl_fh_o,
    output logic [N_FN-1:0]              tbl_irq_o,
    output logic [N_FN-1:0]              tbl_xlat_o
);

    typedef struct packed {
        logic [N_FN-1:0][FID_W-1:0] fid;
        logic [N_FN-1:0][2:0]       st;
        logic [N_FN-1:0][FH_W-1:0]  fh;
        logic [N_FN-1:0]            irq;
        logic [N_FN-1:0]            xl;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (!rst_n) begin
            for (int i = 0; i < N_FN; i++) begin
                tbl_d.fid[i]                = strap_fid_i[i];
                tbl_d.st[i]                 = strap_state_i[i];
                tbl_d.irq[i]                = strap_irq_i[i];
                tbl_d.xl[i]                 = strap_xlat_i[i];
                tbl_d.fh[i]                 = '0;
                tbl_d.fh[i][IDX_W-1:0]      = IDX_W'(i);
                tbl_d.fh[i][FH_EN_BIT]      = (strap_state_i[i] == FS_ENA) ||
                                              (strap_state_i[i] == FS_BLK);
            end
        end else if (upd_en_i) begin
            tbl_d.st[upd_idx_i] = upd_state_i;
            if (upd_clr_en_i) begin
                tbl_d.fh[upd_idx_i][FH_EN_BIT] = 1'b0;
            end
            if (upd_clr_irq_i) begin
                tbl_d.irq[upd_idx_i] = 1'b0;
            end
            if (upd_clr_xlat_i) begin
                tbl_d.xl[upd_idx_i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        tbl_q <= tbl_d;
    end

    assign tbl_fid_o   = tbl_q.fid;
    assign tbl_state_o = tbl_q.st;
    assign tbl_fh_o    = tbl_q.fh;
    assign tbl_irq_o   = tbl_q.irq;
    assign tbl_xlat_o  = tbl_q.xl;

endmodule

// File: rtl/fn_lookup.sv
module fn_lookup
    import fn_cfg_pkg::*;
#(
    parameter int N_FN  = 8,
    parameter int IDX_W = $clog2(N_FN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid_i,
    input  logic [1:0]                 req_op_i,
    input  logic [FID_W-1:0]           req_fid_i,
    input  logic [LEN_W-1:0]           req_len_i,
    input  logic [N_FN-1:0][FID_W-1:0] tbl_fid_i,
    output logic                       lk_vld_o,
    output logic [1:0]                 lk_op_o,
    output logic                       lk_short_o,
    output logic                       lk_hit_o,
    output logic [IDX_W-1:0]           lk_idx_o
);

    typedef struct packed {
        logic             vld;
        logic [1:0]       op;
        logic             short_len;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d           = lk_q;
        lk_d.vld       = req_valid_i && (req_op_i != OP_NONE);
        lk_d.op        = req_op_i;
        lk_d.short_len = req_len_i < LEN_W'(MIN_LEN);
        lk_d.hit       = 1'b0;
        lk_d.idx       = '0;
        // descending scan: the lowest matching slot is written last and wins
        for (int i = N_FN - 1; i >= 0; i--) begin
            if (tbl_fid_i[i] == req_fid_i) begin
                lk_d.hit = 1'b1;
                lk_d.idx = IDX_W'(i);
            end
        end
        if (!rst_n) begin
            lk_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        lk_q <= lk_d;
    end

    assign lk_vld_o   = lk_q.vld;
    assign lk_op_o    = lk_q.op;
    assign lk_short_o = lk_q.short_len;
    assign lk_hit_o   = lk_q.hit;
    assign lk_idx_o   = lk_q.idx;

endmodule

// File: rtl/fn_resp.sv
module fn_resp
    import fn_cfg_pkg::*;
#(
    parameter int N_FN  = 8,
    parameter int IDX_W = $clog2(N_FN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_vld_i,
    input  logic [1:0]           lk_op_i,
    input  logic                 lk_short_i,
    input  logic                 lk_hit_i,
    input  logic [IDX_W-1:0]     lk_idx_i,
    input  logic [N_FN-1:0][2:0] tbl_state_i,
    input  logic [N_FN-1:0]      tbl_irq_i,
    input  logic [N_FN-1:0]      tbl_xlat_i,
    output logic                 upd_en_o,
    output logic [IDX_W-1:0]     upd_idx_o,
    output logic [2:0]           upd_state_o,
    output logic                 upd_clr_en_o,
    output logic                 upd_clr_irq_o,
    output logic                 upd_clr_xlat_o,
    output logic                 rsp_valid_o,
    output logic [RC_W-1:0]      rsp_code_o,
    output logic                 irq_down_o,
    output logic                 xlat_down_o,
    output logic [IDX_W-1:0]     down_idx_o
);

    typedef struct packed {
        logic             vld;
        logic [RC_W-1:0]  code;
        logic             irq;
        logic             xl;
        logic [IDX_W-1:0] idx;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [2:0] cur_st;
    logic       cur_irq;
    logic       cur_xl;

    assign cur_st  = tbl_state_i[lk_idx_i];
    assign cur_irq = tbl_irq_i[lk_idx_i];
    assign cur_xl  = tbl_xlat_i[lk_idx_i];

    always_comb begin
        rsp_d          = '0;
        rsp_d.vld      = lk_vld_i;
        rsp_d.code     = RC_NOACT;
        rsp_d.idx      = lk_idx_i;
        upd_en_o       = 1'b0;
        upd_idx_o      = lk_idx_i;
        upd_state_o    = cur_st;
        upd_clr_en_o   = 1'b0;
        upd_clr_irq_o  = 1'b0;
        upd_clr_xlat_o = 1'b0;

        if (lk_short_i) begin
            rsp_d.code = RC_SHORT;
        end else if (!lk_hit_i) begin
            rsp_d.code = RC_UNKNOWN;
        end else if (cur_st == FS_RSV) begin
            rsp_d.code = RC_RSV;
        end else begin
            unique case (lk_op_i)
                OP_CFG: begin
                    if (cur_st == FS_STBY) begin
                        upd_en_o    = lk_vld_i;
                        upd_state_o = FS_DIS;
                        rsp_d.code  = RC_NORMAL;
                    end
                end
                OP_DECFG: begin
                    if (cur_st != FS_STBY) begin
                        upd_en_o       = lk_vld_i;
                        upd_state_o    = FS_STBY;
                        upd_clr_irq_o  = cur_irq;
                        upd_clr_xlat_o = cur_xl;
                        rsp_d.irq      = lk_vld_i && cur_irq;
                        rsp_d.xl       = lk_vld_i && cur_xl;
                        rsp_d.code     = RC_NORMAL;
                    end
                end
                OP_RST: begin
                    if (cur_st != FS_STBY) begin
                        upd_en_o     = lk_vld_i;
                        upd_state_o  = FS_DIS;
                        upd_clr_en_o = 1'b1;
                        rsp_d.code   = RC_NORMAL;
                    end
                end
                default: begin
                    rsp_d.code = RC_NOACT;
                end
            endcase
        end

        if (!rst_n) begin
            rsp_d    = '0;
            upd_en_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.vld;
    assign rsp_code_o  = rsp_q.code;
    assign irq_down_o  = rsp_q.irq;
    assign xlat_down_o = rsp_q.xl;
    assign down_idx_o  = rsp_q.idx;

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo
    import fn_cfg_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  evt_t  push_evt_i,
    input  logic  pop_i,
    output evt_t  head_o,
    output logic  pending_o,
    output logic  ovf_o
);

    typedef struct packed {
        evt_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_t;

    fifo_t f_d, f_q;

    logic cls_ok;
    logic is_full;
    logic do_pop;
    logic do_push;
    evt_t ent;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        cls_ok  = push_i && ((push_evt_i.cls == CLS_ERR) ||
                             (push_evt_i.cls == CLS_AVAIL));
        is_full = f_q.cnt == CNT_W'(DEPTH);
        do_pop  = pop_i && (f_q.cnt != '0);
        do_push = cls_ok && (!is_full || do_pop);

        ent = push_evt_i;
        if (push_evt_i.cls == CLS_AVAIL) begin
            ent.err  = '0;
            ent.addr = '0;
        end

        if (do_pop) begin
            f_d.rd = ptr_inc(f_q.rd);
        end
        if (do_push) begin
            f_d.mem[f_q.wr] = ent;
            f_d.wr          = ptr_inc(f_q.wr);
        end
        if (do_push && !do_pop) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            f_d.cnt = f_q.cnt - 1'b1;
        end
        if (cls_ok && !do_push) begin
            f_d.ovf = 1'b1;
        end

        if (!rst_n) begin
            f_d.rd  = '0;
            f_d.wr  = '0;
            f_d.cnt = '0;
            f_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

    assign head_o    = f_q.mem[f_q.rd];
    assign pending_o = f_q.cnt != '0;
    assign ovf_o     = f_q.ovf;

endmodule

// File: rtl/fn_cfg_ctrl.sv
module fn_cfg_ctrl
    import fn_cfg_pkg::*;
#(
    parameter int N_FN      = 8,
    parameter int EVT_DEPTH = 8,
    localparam int IDX_W    = $clog2(N_FN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_FN-1:0][31:0]      strap_fid_i,
    input  logic [N_FN-1:0][2:0]       strap_state_i,
    input  logic [N_FN-1:0]            strap_irq_i,
    input  logic [N_FN-1:0]            strap_xlat_i,
    input  logic                       req_valid_i,
    input  logic [1:0]                 req_op_i,
    input  logic [31:0]                req_fid_i,
    input  logic [15:0]                req_len_i,
    output logic                       rsp_valid_o,
    output logic [15:0]                rsp_code_o,
    output logic                       irq_down_o,
    output logic                       xlat_down_o,
    output logic [IDX_W-1:0]           down_idx_o,
    output logic [N_FN-1:0][2:0]       fn_state_o,
    output logic [N_FN-1:0][31:0]      fn_handle_o,
    input  logic                       evt_push_i,
    input  logic [1:0]                 evt_cls_i,
    input  logic [31:0]                evt_fid_i,
    input  logic [31:0]                evt_fh_i,
    input  logic [31:0]                evt_err_i,
    input  logic [63:0]                evt_addr_i,
    input  logic [15:0]                evt_code_i,
    input  logic                       evt_pop_i,
    output logic                       evt_pending_o,
    output logic [1:0]                 evt_cls_o,
    output logic [31:0]                evt_fid_o,
    output logic [31:0]                evt_fh_o,
    output logic [31:0]                evt_err_o,
    output logic [63:0]                evt_addr_o,
    output logic [15:0]                evt_code_o,
    output logic                       evt_ovf_o
);

    logic [N_FN-1:0][FID_W-1:0] tbl_fid;
    logic [N_FN-1:0][2:0]       tbl_state;
    logic [N_FN-1:0]            tbl_irq;
    logic [N_FN-1:0]            tbl_xlat;

    logic                 lk_vld;
    logic [1:0]           lk_op;
    logic                 lk_short;
    logic                 lk_hit;
    logic [IDX_W-1:0]     lk_idx;

    logic                 upd_en;
    logic [IDX_W-1:0]     upd_idx;
    logic [2:0]           upd_state;
    logic                 upd_clr_en;
    logic                 upd_clr_irq;
    logic                 upd_clr_xlat;

    evt_t push_evt;
    evt_t head_evt;

    fn_table #(.N_FN(N_FN), .IDX_W(IDX_W)) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_fid_i    (strap_fid_i),
        .strap_state_i  (strap_state_i),
        .strap_irq_i    (strap_irq_i),
        .strap_xlat_i   (strap_xlat_i),
        .upd_en_i       (upd_en),
        .upd_idx_i      (upd_idx),
        .upd_state_i    (upd_state),
        .upd_clr_en_i   (upd_clr_en),
        .upd_clr_irq_i  (upd_clr_irq),
        .upd_clr_xlat_i (upd_clr_xlat),
        .tbl_fid_o      (tbl_fid),
        .tbl_state_o    (tbl_state),
        .tbl_fh_o       (fn_handle_o),
        .tbl_irq_o      (tbl_irq),
        .tbl_xlat_o     (tbl_xlat)
    );

    fn_lookup #(.N_FN(N_FN), .IDX_W(IDX_W)) u_lookup (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_op_i    (req_op_i),
        .req_fid_i   (req_fid_i),
        .req_len_i   (req_len_i),
        .tbl_fid_i   (tbl_fid),
        .lk_vld_o    (lk_vld),
        .lk_op_o     (lk_op),
        .lk_short_o  (lk_short),
        .lk_hit_o    (lk_hit),
        .lk_idx_o    (lk_idx)
    );

    fn_resp #(.N_FN(N_FN), .IDX_W(IDX_W)) u_resp (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_vld_i       (lk_vld),
        .lk_op_i        (lk_op),
        .lk_short_i     (lk_short),
        .lk_hit_i       (lk_hit),
        .lk_idx_i       (lk_idx),
        .tbl_state_i    (tbl_state),
        .tbl_irq_i      (tbl_irq),
        .tbl_xlat_i     (tbl_xlat),
        .upd_en_o       (upd_en),
        .upd_idx_o      (upd_idx),
        .upd_state_o    (upd_state),
        .upd_clr_en_o   (upd_clr_en),
        .upd_clr_irq_o  (upd_clr_irq),
        .upd_clr_xlat_o (upd_clr_xlat),
        .rsp_valid_o    (rsp_valid_o),
        .rsp_code_o     (rsp_code_o),
        .irq_down_o     (irq_down_o),
        .xlat_down_o    (xlat_down_o),
        .down_idx_o     (down_idx_o)
    );

    assign push_evt.cls  = evt_cls_i;
    assign push_evt.fid  = evt_fid_i;
    assign push_evt.fh   = evt_fh_i;
    assign push_evt.err  = evt_err_i;
    assign push_evt.addr = evt_addr_i;
    assign push_evt.code = evt_code_i;

    evt_fifo #(.DEPTH(EVT_DEPTH)) u_evtq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (evt_push_i),
        .push_evt_i (push_evt),
        .pop_i      (evt_pop_i),
        .head_o     (head_evt),
        .pending_o  (evt_pending_o),
        .ovf_o      (evt_ovf_o)
    );

    assign fn_state_o = tbl_state;
    assign evt_cls_o  = head_evt.cls;
    assign evt_fid_o  = head_evt.fid;
    assign evt_fh_o   = head_evt.fh;
    assign evt_err_o  = head_evt.err;
    assign evt_addr_o = head_evt.addr;
    assign evt_code_o = head_evt.code;

endmodule

// File: rtl/fn_cfg_chk.sv
module fn_cfg_chk #(
    parameter int N_FN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid_i,
    input logic [1:0]           req_op_i,
    input logic                 rsp_valid_o,
    input logic [15:0]          rsp_code_o,
    input logic                 irq_down_o,
    input logic                 xlat_down_o,
    input logic [N_FN-1:0][2:0] fn_state_o,
    input logic                 evt_push_i,
    input logic [1:0]           evt_cls_i,
    input logic                 evt_pending_o,
    input logic                 evt_ovf_o
);

    // R8: every real request is answered two edges later
    a_r8_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i != 2'd3) |=> ##1 rsp_valid_o);

    // R8: no response without a request two edges earlier
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ($past(req_valid_i, 2) && $past(req_op_i, 2) != 2'd3));

    // R2..R7: only the five defined codes
    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_code_o inside {16'h0010, 16'h0020, 16'h0009,
                                            16'h0300, 16'h09F0}));

    // R6: teardown strobes only ride on a normal completion
    a_r6_strobe_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_down_o || xlat_down_o) |-> (rsp_valid_o && rsp_code_o == 16'h0010));

    // R4: a reserved function never leaves that state
    for (genvar i = 0; i < N_FN; i++) begin : g_rsv
        a_r4_rsv_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (fn_state_o[i] == 3'd0) |=> (fn_state_o[i] == 3'd0));
    end

    // R11: an accepted push leaves something pending
    a_r11_push_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_push_i && (evt_cls_i == 2'd1 || evt_cls_i == 2'd2)) |=> evt_pending_o);

    // R11: an empty queue with no push stays empty, pop or not
    a_r11_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pending_o && !evt_push_i) |=> !evt_pending_o);

    // R12: the overflow flag is sticky
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf_o |=> evt_ovf_o);

endmodule

bind fn_cfg_ctrl fn_cfg_chk #(.N_FN(N_FN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_op_i      (req_op_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_code_o    (rsp_code_o),
    .irq_down_o    (irq_down_o),
    .xlat_down_o   (xlat_down_o),
    .fn_state_o    (fn_state_o),
    .evt_push_i    (evt_push_i),
    .evt_cls_i     (evt_cls_i),
    .evt_pending_o (evt_pending_o),
    .evt_ovf_o     (evt_ovf_o)
);

// File: tb/sim_fn_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_fn_cfg_ctrl;

    localparam int N = 8;
    localparam logic [2:0] S_RSV = 3'd0, S_STBY = 3'd1, S_DIS = 3'd2,
                           S_ENA = 3'd3, S_BLK = 3'd4;
    localparam logic [1:0] CFG = 2'd0, DECFG = 2'd1, RST = 2'd2, NOP = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0][31:0] strap_fid;
    logic [N-1:0][2:0]  strap_state;
    logic [N-1:0]       strap_irq;
    logic [N-1:0]       strap_xlat;

    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_fid = '0;
    logic [15:0] req_len = '0;
    logic        rsp_valid, irq_down, xlat_down;
    logic [15:0] rsp_code;
    logic [2:0]  down_idx;
    logic [N-1:0][2:0]  fn_state;
    logic [N-1:0][31:0] fn_handle;

    logic        evt_push = 1'b0, evt_pop = 1'b0;
    logic [1:0]  evt_cls = '0;
    logic [31:0] evt_fid = '0, evt_fh = '0, evt_err = '0;
    logic [63:0] evt_addr = '0;
    logic [15:0] evt_code = '0;
    logic        evt_pending, evt_ovf;
    logic [1:0]  h_cls;
    logic [31:0] h_fid, h_fh, h_err;
    logic [63:0] h_addr;
    logic [15:0] h_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fn_cfg_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .strap_fid_i(strap_fid), .strap_state_i(strap_state),
        .strap_irq_i(strap_irq), .strap_xlat_i(strap_xlat),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_fid_i(req_fid),
        .req_len_i(req_len),
        .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
        .irq_down_o(irq_down), .xlat_down_o(xlat_down), .down_idx_o(down_idx),
        .fn_state_o(fn_state), .fn_handle_o(fn_handle),
        .evt_push_i(evt_push), .evt_cls_i(evt_cls), .evt_fid_i(evt_fid),
        .evt_fh_i(evt_fh), .evt_err_i(evt_err), .evt_addr_i(evt_addr),
        .evt_code_i(evt_code), .evt_pop_i(evt_pop),
        .evt_pending_o(evt_pending), .evt_cls_o(h_cls), .evt_fid_o(h_fid),
        .evt_fh_o(h_fh), .evt_err_o(h_err), .evt_addr_o(h_addr),
        .evt_code_o(h_code), .evt_ovf_o(evt_ovf)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input string tag, input logic [1:0] op, input logic [31:0] fid,
                          input logic [15:0] len, input bit exp_rsp, input logic [15:0] exp_code,
                          input bit exp_irq, input bit exp_xl, input logic [2:0] exp_idx);
        req_valid = 1'b1; req_op = op; req_fid = fid; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R8 no early response"}, 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check({tag, " R8 response valid"}, 64'(rsp_valid), 64'(exp_rsp));
        if (exp_rsp) check({tag, " code"}, 64'(rsp_code), 64'(exp_code));
        check({tag, " R6 irq strobe"}, 64'(irq_down), 64'(exp_irq));
        check({tag, " R6 xlat strobe"}, 64'(xlat_down), 64'(exp_xl));
        if (exp_irq || exp_xl) check({tag, " R6 down idx"}, 64'(down_idx), 64'(exp_idx));
        @(negedge clk);
        check({tag, " R8 single pulse"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic push_evt(input logic [1:0] cls, input logic [31:0] fid, input logic [31:0] fh,
                            input logic [31:0] err, input logic [63:0] addr, input logic [15:0] code);
        evt_push = 1'b1; evt_cls = cls; evt_fid = fid; evt_fh = fh;
        evt_err = err; evt_addr = addr; evt_code = code;
        @(negedge clk);
        evt_push = 1'b0;
    endtask

    task automatic pop_evt();
        evt_pop = 1'b1;
        @(negedge clk);
        evt_pop = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin
            check($sformatf("R1 state slot %0d", i), 64'(fn_state[i]), 64'(strap_state[i]));
            check($sformatf("R1 handle slot %0d", i), 64'(fn_handle[i]),
                  64'({(strap_state[i] == S_ENA || strap_state[i] == S_BLK), 28'd0, 3'(i)}));
        end
        check("R1 queue empty", 64'(evt_pending), 64'd0);
        check("R1 overflow clear", 64'(evt_ovf), 64'd0);
        check("R1 no response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_short();
        do_req("R2 short known", CFG, 32'h100, 16'd15, 1'b1, 16'h0300, 1'b0, 1'b0, 3'd0);
        check("R2 state unchanged", 64'(fn_state[0]), 64'(S_STBY));
        do_req("R2 short unknown", CFG, 32'h999, 16'd15, 1'b1, 16'h0300, 1'b0, 1'b0, 3'd0);
        do_req("R2 short reserved", DECFG, 32'h101, 16'd0, 1'b1, 16'h0300, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_unknown();
        do_req("R3 unknown fid", DECFG, 32'h999, 16'd40, 1'b1, 16'h09F0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_reserved();
        do_req("R4 cfg reserved", CFG, 32'h101, 16'd16, 1'b1, 16'h0009, 1'b0, 1'b0, 3'd0);
        do_req("R4 decfg reserved", DECFG, 32'h101, 16'd16, 1'b1, 16'h0009, 1'b0, 1'b0, 3'd0);
        do_req("R4 reset reserved", RST, 32'h101, 16'd16, 1'b1, 16'h0009, 1'b0, 1'b0, 3'd0);
        check("R4 still reserved", 64'(fn_state[1]), 64'(S_RSV));
    endtask

    task automatic t_configure();
        do_req("R5 cfg standby len16", CFG, 32'h100, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        check("R5 now disabled", 64'(fn_state[0]), 64'(S_DIS));
        do_req("R5 cfg disabled", CFG, 32'h100, 16'd16, 1'b1, 16'h0020, 1'b0, 1'b0, 3'd0);
        do_req("R5 cfg blocked", CFG, 32'h103, 16'd16, 1'b1, 16'h0020, 1'b0, 1'b0, 3'd0);
        check("R5 blocked kept", 64'(fn_state[3]), 64'(S_BLK));
        do_req("R8 op3 ignored", NOP, 32'h104, 16'd16, 1'b0, 16'h0, 1'b0, 1'b0, 3'd0);
        check("R8 op3 no change", 64'(fn_state[4]), 64'(S_DIS));
    endtask

    task automatic t_deconfigure();
        do_req("R6 decfg standby", DECFG, 32'h106, 16'd16, 1'b1, 16'h0020, 1'b0, 1'b0, 3'd0);
        check("R6 standby kept", 64'(fn_state[6]), 64'(S_STBY));
        do_req("R6 decfg enabled", DECFG, 32'h107, 16'd16, 1'b1, 16'h0010, 1'b1, 1'b1, 3'd7);
        check("R6 enabled to standby", 64'(fn_state[7]), 64'(S_STBY));
        do_req("R6 decfg again", DECFG, 32'h107, 16'd16, 1'b1, 16'h0020, 1'b0, 1'b0, 3'd0);
        do_req("R6 reconfigure", CFG, 32'h107, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        do_req("R6 decfg no resources", DECFG, 32'h107, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        do_req("R6 decfg blocked xlat only", DECFG, 32'h103, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b1, 3'd3);
        check("R6 blocked to standby", 64'(fn_state[3]), 64'(S_STBY));
    endtask

    task automatic t_reset_op();
        do_req("R7 reset enabled", RST, 32'h102, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        check("R7 enabled to disabled", 64'(fn_state[2]), 64'(S_DIS));
        check("R7 enable bit cleared", 64'(fn_handle[2]), 64'h2);
        check("R9 duplicate slot untouched", 64'(fn_state[5]), 64'(S_STBY));
        do_req("R7 reset standby", RST, 32'h106, 16'd16, 1'b1, 16'h0020, 1'b0, 1'b0, 3'd0);
        check("R7 standby kept", 64'(fn_state[6]), 64'(S_STBY));
        do_req("R7 reset disabled", RST, 32'h104, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        check("R7 disabled kept", 64'(fn_state[4]), 64'(S_DIS));
    endtask

    task automatic t_duplicate();
        do_req("R9 decfg duplicate fid", DECFG, 32'h102, 16'd16, 1'b1, 16'h0010, 1'b1, 1'b0, 3'd2);
        check("R9 lowest slot moved", 64'(fn_state[2]), 64'(S_STBY));
        check("R9 higher slot untouched", 64'(fn_state[5]), 64'(S_STBY));
        do_req("R9 cfg duplicate fid", CFG, 32'h102, 16'd16, 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        check("R9 lowest slot configured", 64'(fn_state[2]), 64'(S_DIS));
        check("R9 higher slot still standby", 64'(fn_state[5]), 64'(S_STBY));
    endtask

    task automatic t_events();
        pop_evt();
        check("R11 pop empty", 64'(evt_pending), 64'd0);
        push_evt(2'd1, 32'hA1, 32'hB1, 32'hC1, 64'h1234_5678_9ABC_DEF0, 16'h0E01);
        check("R11 pending after push", 64'(evt_pending), 64'd1);
        push_evt(2'd2, 32'hA2, 32'hB2, 32'hFFFF, 64'hFFFF, 16'h0E02);
        push_evt(2'd3, 32'hA3, 32'hB3, 32'h0, 64'h0, 16'h0E03);
        push_evt(2'd0, 32'hA4, 32'hB4, 32'h0, 64'h0, 16'h0E04);
        check("R10 error class", 64'(h_cls), 64'd1);
        check("R10 error fid", 64'(h_fid), 64'hA1);
        check("R10 error handle", 64'(h_fh), 64'hB1);
        check("R10 error word", 64'(h_err), 64'hC1);
        check("R10 error address", h_addr, 64'h1234_5678_9ABC_DEF0);
        check("R10 error code", 64'(h_code), 64'h0E01);
        pop_evt();
        check("R10 avail class", 64'(h_cls), 64'd2);
        check("R10 avail fid", 64'(h_fid), 64'hA2);
        check("R10 avail handle", 64'(h_fh), 64'hB2);
        check("R10 avail err zero", 64'(h_err), 64'd0);
        check("R10 avail addr zero", h_addr, 64'd0);
        check("R10 avail code", 64'(h_code), 64'h0E02);
        pop_evt();
        check("R10 bad classes dropped", 64'(evt_pending), 64'd0);
        pop_evt();
        push_evt(2'd2, 32'hA5, 32'hB5, 32'h0, 64'h0, 16'h0E05);
        check("R11 pop on empty harmless", 64'(h_code), 64'h0E05);
        pop_evt();
        check("R11 empty again", 64'(evt_pending), 64'd0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) push_evt(2'd2, 32'h0, 32'h0, 32'h0, 64'h0, 16'(i));
        evt_pop = 1'b1;
        push_evt(2'd2, 32'h0, 32'h0, 32'h0, 64'h0, 16'd8);
        evt_pop = 1'b0;
        check("R12 push with pop at full no overflow", 64'(evt_ovf), 64'd0);
        for (int i = 1; i <= 8; i++) begin
            check($sformatf("R12 order %0d", i), 64'(h_code), 64'(i));
            pop_evt();
        end
        check("R12 drained", 64'(evt_pending), 64'd0);
        for (int i = 0; i < 9; i++) begin
            push_evt(2'd1, 32'h0, 32'h0, 32'h0, 64'h0, 16'(16 + i));
            if (i == 7) check("R12 full no overflow yet", 64'(evt_ovf), 64'd0);
        end
        check("R12 overflow set", 64'(evt_ovf), 64'd1);
        for (int i = 0; i < 8; i++) begin
            check($sformatf("R12 kept entry %0d", i), 64'(h_code), 64'(16 + i));
            pop_evt();
        end
        check("R12 dropped ninth", 64'(evt_pending), 64'd0);
        check("R12 overflow sticky", 64'(evt_ovf), 64'd1);
    endtask

    initial begin
        strap_fid   = '{32'h107, 32'h106, 32'h102, 32'h104, 32'h103, 32'h102, 32'h101, 32'h100};
        strap_state = '{S_ENA, S_STBY, S_STBY, S_DIS, S_BLK, S_ENA, S_RSV, S_STBY};
        strap_irq   = 8'b1000_0101;
        strap_xlat  = 8'b1000_1001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_unknown();
        t_reserved();
        t_configure();
        t_deconfigure();
        t_reset_op();
        t_duplicate();
        t_events();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule